// File: doc/BRIEF.md
# Privilege-Level Event Count Filter

This block decides, cycle by cycle, whether a performance event may be added to one event counter. It sees the privilege level the processor is running at (0 to 3), the security world, whether streaming vector mode is active, whether the processor is inside a transaction, and whether the current event can be attributed to this processor. It combines that state with the filter fields of one counter's configuration word and produces a single allow signal, `count_ok`.

The block is pure combinational logic with no clock and no reset. It contains no state machine, so its only "states" are the input classes it decodes. The level gate chooses a rule by privilege level and world. The mode gate applies the vector-mode and transaction filters. The top ANDs the two results.

World encoding: `2'b00` secure, `2'b01` non-secure, `2'b10` realm, `2'b11` reserved. Vector-mode field encoding: `2'b01` suppresses counting while streaming, `2'b10` suppresses counting while not streaming, and `2'b00` and `2'b11` have no effect. The parameter `HAS_SEC_L2` (default 1) says whether a secure level-2 mode exists.

Top module: `evt_count_filter`

## Requirements
- R1: In the secure world (`2'b00`), level 1 is blocked when `f_p` is 1, and level 0 is blocked when `f_u` is 1.
- R2: In the non-secure world (`2'b01`), level 1 is blocked exactly when `f_nsk` differs from `f_p`, and level 0 is blocked exactly when `f_nsu` differs from `f_u`.
- R3: In the realm world (`2'b10`), level 1 is blocked when `f_rlk` differs from `f_p`, and level 0 is blocked when `f_rlu` differs from `f_u`.
- R4: At non-secure level 2, counting is blocked when `f_nsh` is 0 and allowed when it is 1, which is the inverse polarity of the other base bits.
- R5: At secure level 2, counting is blocked when `f_sh` equals `f_nsh`. At realm level 2, counting is blocked when `f_rlh` equals `f_nsh`.
- R6: At level 3, counting is blocked exactly when `f_m` differs from `f_p`, whatever the world input says.
- R7: `f_vs` = `2'b01` blocks counting while `streaming` is 1. `f_vs` = `2'b10` blocks counting while `streaming` is 0. Values `2'b00` and `2'b11` have no effect.
- R8: When `f_t` is 1, an event with `attributable` = 1 is blocked while `in_txn` = 0. Unattributable events, and events inside a transaction, are unaffected.
- R9: `count_ok` is the AND of the level rule and the mode rules. With every input at zero (secure level 0, all fields clear), `count_ok` is 1.
- R10: The reserved world value `2'b11` blocks counting at levels 0, 1 and 2.
- R11: With `HAS_SEC_L2` = 0, `f_sh` is ignored and read as 0, so secure level 2 is blocked exactly when `f_nsh` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| priv_lvl | input | 2 | Current privilege level, 0 to 3 |
| world | input | 2 | Security world: 00 secure, 01 non-secure, 10 realm, 11 reserved |
| streaming | input | 1 | 1 while streaming vector mode is active |
| in_txn | input | 1 | 1 while in transactional state |
| attributable | input | 1 | 1 when the event is attributable to this processor |
| f_p | input | 1 | Level-1 base filter bit |
| f_u | input | 1 | Level-0 base filter bit |
| f_nsk | input | 1 | Non-secure level-1 modifier |
| f_nsu | input | 1 | Non-secure level-0 modifier |
| f_nsh | input | 1 | Level-2 base bit (1 allows) |
| f_m | input | 1 | Level-3 modifier |
| f_sh | input | 1 | Secure level-2 modifier |
| f_rlk | input | 1 | Realm level-1 modifier |
| f_rlu | input | 1 | Realm level-0 modifier |
| f_rlh | input | 1 | Realm level-2 modifier |
| f_vs | input | 2 | Vector-mode filter |
| f_t | input | 1 | Non-transactional filter |
| count_ok | output | 1 | 1 when the event may be counted |

## Verification
The bound checker evaluates these rules whenever the inputs change:
- The non-secure level-1 and level-2 rules.
- The level-3 rule.
- Both vector-mode blocks.
- The transaction block.
- Reserved-world blocking.

Each of these checks only that counting is blocked when a rule says it must be. Showing that counting is allowed whenever every rule passes needs the bench's exhaustive sweep, which covers every level, world and privilege-filter combination and every vector-mode and transaction pattern. The bench also compares a second instance built with `HAS_SEC_L2` = 0 against the default one, which confirms that `f_sh` is ignored there.

// File: rtl/evf_pkg.sv
package evf_pkg;

    localparam int LVL_W   = 2;
    localparam int WORLD_W = 2;
    localparam int VS_W    = 2;

    typedef enum logic [WORLD_W-1:0] {
        WORLD_SEC   = 2'b00,
        WORLD_NS    = 2'b01,
        WORLD_REALM = 2'b10,
        WORLD_RSVD  = 2'b11
    } world_e;

    typedef enum logic [VS_W-1:0] {
        VS_NONE        = 2'b00,
        VS_NO_STREAM   = 2'b01,
        VS_NO_NONSTRM  = 2'b10,
        VS_RSVD        = 2'b11
    } vs_e;

    typedef struct packed {
        logic p;
        logic u;
        logic nsk;
        logic nsu;
        logic nsh;
        logic m;
        logic sh;
        logic rlk;
        logic rlu;
        logic rlh;
    } lvl_cfg_t;

endpackage

// File: rtl/evf_level_gate.sv
module evf_level_gate
    import evf_pkg::*;
#(
    parameter bit HAS_SEC_L2 = 1'b1
) (
    input  logic [LVL_W-1:0] lvl,
    input  world_e           wld,
    input  lvl_cfg_t         cfg,
    output logic             allow
);

    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'((1 << LVL_W) - 1);

    logic sh_eff;
    logic base_bit;
    logic ns_bit;
    logic rl_bit;
    logic low_allow;
    logic l2_allow;

    // A missing secure level 2 makes its modifier read as zero
    generate
        if (HAS_SEC_L2) begin : g_sec_l2
            assign sh_eff = cfg.sh;
        end else begin : g_no_sec_l2
            assign sh_eff = 1'b0;
        end
    endgenerate

    // Levels 0 and 1 share one rule and differ only in which bits they pick
    always_comb begin
        base_bit = lvl[0] ? cfg.p   : cfg.u;
        ns_bit   = lvl[0] ? cfg.nsk : cfg.nsu;
        rl_bit   = lvl[0] ? cfg.rlk : cfg.rlu;
        unique case (wld)
            WORLD_SEC:   low_allow = ~base_bit;
            WORLD_NS:    low_allow = (ns_bit == base_bit);
            WORLD_REALM: low_allow = (rl_bit == base_bit);
            default:     low_allow = 1'b0;
        endcase
    end

    // Level 2 uses an inverted-polarity base bit
    always_comb begin
        unique case (wld)
            WORLD_SEC:   l2_allow = (sh_eff != cfg.nsh);
            WORLD_NS:    l2_allow = cfg.nsh;
            WORLD_REALM: l2_allow = (cfg.rlh != cfg.nsh);
            default:     l2_allow = 1'b0;
        endcase
    end

    always_comb begin
        if (lvl == TOP_LVL) begin
            allow = (cfg.m == cfg.p);
        end else if (lvl[1]) begin
            allow = l2_allow;
        end else begin
            allow = low_allow;
        end
    end

endmodule

// File: rtl/evf_mode_gate.sv
module evf_mode_gate
    import evf_pkg::*;
(
    input  vs_e  vs,
    input  logic streaming,
    input  logic in_txn,
    input  logic attributable,
    input  logic t_flt,
    output logic allow
);

    logic vs_allow;
    logic txn_allow;

    always_comb begin
        unique case (vs)
            VS_NO_STREAM:  vs_allow = ~streaming;
            VS_NO_NONSTRM: vs_allow = streaming;
            default:       vs_allow = 1'b1;
        endcase
        txn_allow = ~(t_flt & attributable & ~in_txn);
        allow     = vs_allow & txn_allow;
    end

endmodule

// File: rtl/evt_count_filter.sv
module evt_count_filter
    import evf_pkg::*;
#(
    parameter bit HAS_SEC_L2 = 1'b1
) (
    input  logic [1:0] priv_lvl,
    input  logic [1:0] world,
    input  logic       streaming,
    input  logic       in_txn,
    input  logic       attributable,
    input  logic       f_p,
    input  logic       f_u,
    input  logic       f_nsk,
    input  logic       f_nsu,
    input  logic       f_nsh,
    input  logic       f_m,
    input  logic       f_sh,
    input  logic       f_rlk,
    input  logic       f_rlu,
    input  logic       f_rlh,
    input  logic [1:0] f_vs,
    input  logic       f_t,
    output logic       count_ok
);

    lvl_cfg_t cfg;
    logic     lvl_allow;
    logic     mode_allow;

    assign cfg = '{p: f_p, u: f_u, nsk: f_nsk, nsu: f_nsu, nsh: f_nsh,
                   m: f_m, sh: f_sh, rlk: f_rlk, rlu: f_rlu, rlh: f_rlh};

    evf_level_gate #(
        .HAS_SEC_L2(HAS_SEC_L2)
    ) u_lvl (
        .lvl   (priv_lvl),
        .wld   (world_e'(world)),
        .cfg   (cfg),
        .allow (lvl_allow)
    );

    evf_mode_gate u_mode (
        .vs           (vs_e'(f_vs)),
        .streaming    (streaming),
        .in_txn       (in_txn),
        .attributable (attributable),
        .t_flt        (f_t),
        .allow        (mode_allow)
    );

    // R9
    assign count_ok = lvl_allow & mode_allow;

endmodule

// File: rtl/evf_checks.sv
module evf_checks (
    input logic [1:0] priv_lvl,
    input logic [1:0] world,
    input logic       streaming,
    input logic       in_txn,
    input logic       attributable,
    input logic       f_p,
    input logic       f_nsk,
    input logic       f_nsh,
    input logic       f_m,
    input logic [1:0] f_vs,
    input logic       f_t,
    input logic       count_ok
);

    always_comb begin
        // R2
        ns_l1_chk: assert (!(priv_lvl == 2'd1 && world == 2'b01 && f_nsk != f_p) || !count_ok);
        // R4
        ns_l2_chk: assert (!(priv_lvl == 2'd2 && world == 2'b01 && !f_nsh) || !count_ok);
        // R6
        top_lvl_chk: assert (!(priv_lvl == 2'd3 && f_m != f_p) || !count_ok);
        // R7
        vs_stream_chk: assert (!(f_vs == 2'b01 && streaming) || !count_ok);
        // R7
        vs_nonstream_chk: assert (!(f_vs == 2'b10 && !streaming) || !count_ok);
        // R8
        txn_chk: assert (!(f_t && attributable && !in_txn) || !count_ok);
        // R10
        rsvd_world_chk: assert (!(priv_lvl != 2'd3 && world == 2'b11) || !count_ok);
    end

endmodule

bind evt_count_filter evf_checks u_chk (.*);

// File: tb/tb_evt_count_filter.sv
module tb_evt_count_filter;

    typedef struct {
        bit [1:0] lvl;
        bit [1:0] wld;
        bit [9:0] flt;   // {p,u,nsk,nsu,nsh,m,sh,rlk,rlu,rlh}
        bit [1:0] vs;
        bit       strm;
        bit       txn;
        bit       attr;
        bit       t;
    } stim_t;

    typedef struct {
        bit    exp_a;
        bit    exp_b;
        string rq_a;
        string rq_b;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [1:0] priv_lvl, world, f_vs;
    logic streaming, in_txn, attributable, f_t;
    logic f_p, f_u, f_nsk, f_nsu, f_nsh, f_m, f_sh, f_rlk, f_rlu, f_rlh;
    logic ok_a, ok_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    item_t q[$];

    evt_count_filter dut (
        .priv_lvl(priv_lvl), .world(world), .streaming(streaming), .in_txn(in_txn),
        .attributable(attributable), .f_p(f_p), .f_u(f_u), .f_nsk(f_nsk), .f_nsu(f_nsu),
        .f_nsh(f_nsh), .f_m(f_m), .f_sh(f_sh), .f_rlk(f_rlk), .f_rlu(f_rlu), .f_rlh(f_rlh),
        .f_vs(f_vs), .f_t(f_t), .count_ok(ok_a));

    evt_count_filter #(.HAS_SEC_L2(1'b0)) dut_nosl2 (
        .priv_lvl(priv_lvl), .world(world), .streaming(streaming), .in_txn(in_txn),
        .attributable(attributable), .f_p(f_p), .f_u(f_u), .f_nsk(f_nsk), .f_nsu(f_nsu),
        .f_nsh(f_nsh), .f_m(f_m), .f_sh(f_sh), .f_rlk(f_rlk), .f_rlu(f_rlu), .f_rlh(f_rlh),
        .f_vs(f_vs), .f_t(f_t), .count_ok(ok_b));

    // Reference model written from the requirements
    function automatic bit model(stim_t s, bit sel2, output string rq);
        bit p, u, nsk, nsu, nsh, m, sh, rlk, rlu, rlh, lv;
        {p, u, nsk, nsu, nsh, m, sh, rlk, rlu, rlh} = s.flt;
        if (!sel2) sh = 1'b0;
        if (s.lvl == 2'd3) begin
            rq = "R6"; lv = (m == p);
        end else if (s.wld == 2'b11) begin
            rq = "R10"; lv = 1'b0;
        end else if (s.lvl == 2'd2) begin
            case (s.wld)
                2'b00: begin rq = sel2 ? "R5" : "R11"; lv = (sh != nsh); end
                2'b01: begin rq = "R4"; lv = nsh; end
                default: begin rq = "R5"; lv = (rlh != nsh); end
            endcase
        end else if (s.wld == 2'b00) begin
            rq = "R1"; lv = (s.lvl == 2'd1) ? !p : !u;
        end else if (s.wld == 2'b01) begin
            rq = "R2"; lv = (s.lvl == 2'd1) ? (nsk == p) : (nsu == u);
        end else begin
            rq = "R3"; lv = (s.lvl == 2'd1) ? (rlk == p) : (rlu == u);
        end
        if (!lv) return 1'b0;
        if ((s.vs == 2'b01 && s.strm) || (s.vs == 2'b10 && !s.strm)) begin
            rq = "R7"; return 1'b0;
        end
        if (s.t && s.attr && !s.txn) begin
            rq = "R8"; return 1'b0;
        end
        if (s.vs != 2'b00 || s.t) rq = (s.vs != 2'b00) ? "R7" : "R8";
        else if (rq == "R1" && s.flt == '0) rq = "R9";
        return 1'b1;
    endfunction

    task automatic drive(stim_t s);
        item_t it;
        @(posedge clk);
        #1;
        priv_lvl = s.lvl; world = s.wld; f_vs = s.vs;
        streaming = s.strm; in_txn = s.txn; attributable = s.attr; f_t = s.t;
        {f_p, f_u, f_nsk, f_nsu, f_nsh, f_m, f_sh, f_rlk, f_rlu, f_rlh} = s.flt;
        it.exp_a = model(s, 1'b1, it.rq_a);
        it.exp_b = model(s, 1'b0, it.rq_b);
        q.push_back(it);
    endtask

    // Monitor: pop and compare away from the driving edge
    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (ok_a !== it.exp_a) begin
                fails++;
                $display("FAIL %s: dut count_ok=%0b expected=%0b lvl=%0d world=%0d", it.rq_a, ok_a, it.exp_a, priv_lvl, world);
            end
            checks++;
            if (ok_b !== it.exp_b) begin
                fails++;
                $display("FAIL %s: dut_nosl2 count_ok=%0b expected=%0b lvl=%0d world=%0d", it.rq_b, ok_b, it.exp_b, priv_lvl, world);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 60000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        stim_t s;
        priv_lvl = '0; world = '0; f_vs = '0; streaming = 0; in_txn = 0; attributable = 0; f_t = 0;
        {f_p, f_u, f_nsk, f_nsu, f_nsh, f_m, f_sh, f_rlk, f_rlu, f_rlh} = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R9: all-zero inputs allow counting
        s = '{lvl: 2'd0, wld: 2'b00, flt: '0, vs: 2'b00, strm: 0, txn: 0, attr: 0, t: 0};
        drive(s);
        // R1 R2 R3 R4 R5 R6 R10 R11: every level, world and privilege filter pattern
        for (int i = 0; i < 16384; i++) begin
            s.lvl = i[1:0]; s.wld = i[3:2]; s.flt = i[13:4];
            s.vs = 2'b00; s.strm = 0; s.txn = 0; s.attr = 0; s.t = 0;
            drive(s);
        end
        // R7 R8 R9: vector-mode and transaction patterns at secure level 0
        for (int j = 0; j < 64; j++) begin
            s.lvl = 2'd0; s.wld = 2'b00; s.flt = '0;
            s.vs = j[1:0]; s.strm = j[2]; s.txn = j[3]; s.attr = j[4]; s.t = j[5];
            drive(s);
        end
        // R9: a passing level rule combined with a blocking mode rule, at level 3
        s = '{lvl: 2'd3, wld: 2'b10, flt: 10'b1000010000, vs: 2'b10, strm: 0, txn: 0, attr: 0, t: 0};
        drive(s);
        s.vs = 2'b11;
        drive(s);
        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule